// File: doc/BRIEF.md
# Registered Integer ALU with Overflow, Trap and Move-Squash Flags

This block is the integer execute unit of a 32-bit RISC core. Each cycle it takes an operation code, two operands (`opnd_s`, `opnd_t`) and an immediate shift amount. One clock later it returns a data result and three flags. The operations are:

- wrapping and overflow-checked addition and subtraction
- bitwise logic
- signed and unsigned set-less-than
- logical, arithmetic and rotating shifts by an immediate or by a register-supplied amount
- conditional moves on a zero or nonzero operand
- upper-half load of an immediate
- compare-and-trap tests

The flags are not acted on here. The surrounding pipeline reads them:

- `ovf_flag` requests an arithmetic overflow exception.
- `trap_flag` requests a trap exception.
- `discard_flag` tells writeback to drop the result of a conditional move whose condition failed.

Top module: `int_alu`

## Requirements
- R1: A synchronous active-high `rst` clears `result` and all three flags to 0 at the next rising edge, whatever the other inputs are.
- R2: Outputs are registered. The inputs present before a rising edge determine the outputs after that edge, and the outputs do not change between edges.
- R3: Code 1 (checked add) and code 3 (checked subtract) return the wrapped two's complement sum or difference. `ovf_flag` is set only when the true signed result does not fit in 32 bits. Code 2 (wrapping add) and code 4 (wrapping subtract) return the same values and never set `ovf_flag`.
- R4: Codes 5, 6, 7 and 8 return s AND t, s OR t, s XOR t and NOT(s OR t).
- R5: Code 9 returns 1 if s < t as signed numbers, else 0. Code 10 makes the same comparison unsigned. Bits 31..1 of the result are always 0.
- R6: Code 11 shifts t left, code 12 shifts t right with zero fill, and code 13 shifts t right filling with copies of t[31]. All three shift by `shamt`.
- R7: Code 14 rotates t right by `shamt`, and code 18 rotates t right by s[4:0]. A rotate amount of 0 returns t unchanged.
- R8: Codes 15, 16, 17 and 18 are the register-amount forms of left shift, logical right shift, arithmetic right shift and rotate. They use only s[4:0] as the amount, and `shamt` and s[31:5] have no effect on them.
- R9: Code 19 returns s when t is 0. Code 20 returns s when t is nonzero. When its condition fails, either code returns 0 and sets `discard_flag`.
- R10: Code 21 returns t shifted left by 16.
- R11: Codes 22 to 27 return 0 and set `trap_flag` when their condition on s and t holds:
  - code 22: signed s >= t
  - code 23: unsigned s >= t
  - code 24: signed s < t
  - code 25: unsigned s < t
  - code 26: s == t
  - code 27: s != t
- R12: Code 0 (no-op) and the unassigned codes 28 to 31 return 0 with every flag low. At most one flag is ever set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_sel | input | 5 | Operation code (see requirements) |
| opnd_s | input | DATA_W | First operand; also supplies the register shift amount |
| opnd_t | input | DATA_W | Second operand; the value shifted, rotated or tested |
| shamt | input | SH_W | Immediate shift or rotate amount |
| result | output | DATA_W | Registered data result |
| ovf_flag | output | 1 | Signed overflow on a checked add or subtract |
| trap_flag | output | 1 | Compare-and-trap condition held |
| discard_flag | output | 1 | Conditional move squashed |

## Verification
A checked add or subtract can overflow in the same cycle that it delivers its wrapped result. Likewise, a conditional move can be squashed in the same cycle that it forces its result to zero. The operand sweep uses sign-boundary values (0x7FFFFFFF, 0x80000000, 0xFFFFFFFF and neighbours), so every signed-overflow corner meets each code. The bench then judges the result word and the flag in the same compare, against a model that computes overflow by 64-bit signed range and not by sign-bit rules. Register-amount shifts receive operands whose upper bits and `shamt` differ from the live amount field, which exposes any use of the wrong amount.

// File: rtl/int_alu_pkg.sv
package int_alu_pkg;
  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_NOP   = 5'd0,
    OP_ADD   = 5'd1,
    OP_ADDU  = 5'd2,
    OP_SUB   = 5'd3,
    OP_SUBU  = 5'd4,
    OP_AND   = 5'd5,
    OP_OR    = 5'd6,
    OP_XOR   = 5'd7,
    OP_NOR   = 5'd8,
    OP_SLT   = 5'd9,
    OP_SLTU  = 5'd10,
    OP_SLL   = 5'd11,
    OP_SRL   = 5'd12,
    OP_SRA   = 5'd13,
    OP_ROTR  = 5'd14,
    OP_SLLV  = 5'd15,
    OP_SRLV  = 5'd16,
    OP_SRAV  = 5'd17,
    OP_ROTRV = 5'd18,
    OP_MOVZ  = 5'd19,
    OP_MOVN  = 5'd20,
    OP_LUI   = 5'd21,
    OP_TGE   = 5'd22,
    OP_TGEU  = 5'd23,
    OP_TLT   = 5'd24,
    OP_TLTU  = 5'd25,
    OP_TEQ   = 5'd26,
    OP_TNE   = 5'd27
  } alu_op_e;

  typedef enum logic [1:0] {
    SH_LEFT      = 2'd0,
    SH_RIGHT_LOG = 2'd1,
    SH_RIGHT_ARI = 2'd2,
    SH_ROT_RIGHT = 2'd3
  } shift_kind_e;

  typedef struct packed {
    logic ovf;
    logic trap;
    logic discard;
  } alu_flags_t;
endpackage

// File: rtl/int_alu_addsub.sv
module int_alu_addsub #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] sum,
  output logic [DATA_W-1:0] diff,
  output logic              add_ovf,
  output logic              sub_ovf,
  output logic              lt_signed,
  output logic              lt_unsigned,
  output logic              equal
);
  localparam int MSB = DATA_W - 1;

  logic [DATA_W:0] diff_ext;

  // One extended subtractor gives the difference and the unsigned borrow.
  assign diff_ext    = {1'b0, a} - {1'b0, b};
  assign diff        = diff_ext[MSB:0];
  assign lt_unsigned = diff_ext[DATA_W];
  assign sum         = a + b;

  // Overflow: operands agree (add) or disagree (sub) in sign,
  // and the result sign departs from a.
  assign add_ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);
  assign sub_ovf = (a[MSB] != b[MSB]) && (diff[MSB] != a[MSB]);

  // Signed less-than from the difference sign, corrected by overflow.
  assign lt_signed = diff[MSB] ^ sub_ovf;
  assign equal     = (diff == '0);
endmodule

// File: rtl/int_alu_shifter.sv
module int_alu_shifter
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] din,
  input  logic [SH_W-1:0]   amt,
  input  shift_kind_e       kind,
  output logic [DATA_W-1:0] dout
);
  function automatic logic [DATA_W-1:0] bit_rev(input logic [DATA_W-1:0] v);
    logic [DATA_W-1:0] r;
    for (int i = 0; i < DATA_W; i++) r[i] = v[DATA_W-1-i];
    return r;
  endfunction

  logic [SH_W:0][DATA_W-1:0] stage;
  logic                      fill;
  logic                      is_left;
  logic                      is_rot;

  assign is_left  = (kind == SH_LEFT);
  assign is_rot   = (kind == SH_ROT_RIGHT);
  assign fill     = (kind == SH_RIGHT_ARI) ? din[DATA_W-1] : 1'b0;
  // A left shift runs through the right-shift network on mirrored data.
  assign stage[0] = is_left ? bit_rev(din) : din;

  for (genvar k = 0; k < SH_W; k++) begin : g_stage
    localparam int D = 1 << k;
    logic [DATA_W-1:0] shifted;
    assign shifted = is_rot ? {stage[k][D-1:0], stage[k][DATA_W-1:D]}
                            : {{D{fill}}, stage[k][DATA_W-1:D]};
    assign stage[k+1] = amt[k] ? shifted : stage[k];
  end

  assign dout = is_left ? bit_rev(stage[SH_W]) : stage[SH_W];
endmodule

// File: rtl/int_alu_logic.sv
module int_alu_logic #(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] and_o,
  output logic [DATA_W-1:0] or_o,
  output logic [DATA_W-1:0] xor_o,
  output logic [DATA_W-1:0] nor_o
);
  assign and_o = a & b;
  assign or_o  = a | b;
  assign xor_o = a ^ b;
  assign nor_o = ~(a | b);
endmodule

// File: rtl/int_alu.sv
module int_alu
  import int_alu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SH_W   = $clog2(DATA_W)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [OP_W-1:0]     op_sel,
  input  logic [DATA_W-1:0]   opnd_s,
  input  logic [DATA_W-1:0]   opnd_t,
  input  logic [SH_W-1:0]     shamt,
  output logic [DATA_W-1:0]   result,
  output logic                ovf_flag,
  output logic                trap_flag,
  output logic                discard_flag
);
  localparam int HALF_W = DATA_W / 2;

  alu_op_e           op;
  logic [DATA_W-1:0] sum, diff, and_v, or_v, xor_v, nor_v, sh_v;
  logic              add_ovf, sub_ovf, lt_s, lt_u, eq;
  logic [SH_W-1:0]   sh_amt;
  shift_kind_e       sh_kind;
  logic              use_reg_amt;
  logic [DATA_W-1:0] res_c;
  alu_flags_t        flg_c;

  assign op = alu_op_e'(op_sel);

  int_alu_addsub #(.DATA_W(DATA_W)) u_addsub (
    .a(opnd_s), .b(opnd_t), .sum(sum), .diff(diff),
    .add_ovf(add_ovf), .sub_ovf(sub_ovf),
    .lt_signed(lt_s), .lt_unsigned(lt_u), .equal(eq)
  );

  int_alu_logic #(.DATA_W(DATA_W)) u_logic (
    .a(opnd_s), .b(opnd_t),
    .and_o(and_v), .or_o(or_v), .xor_o(xor_v), .nor_o(nor_v)
  );

  // Shift control: register-amount forms take the low bits of s.
  always_comb begin
    use_reg_amt = 1'b0;
    sh_kind     = SH_LEFT;
    unique case (op)
      OP_SRL:   sh_kind = SH_RIGHT_LOG;
      OP_SRA:   sh_kind = SH_RIGHT_ARI;
      OP_ROTR:  sh_kind = SH_ROT_RIGHT;
      OP_SLLV:  use_reg_amt = 1'b1;
      OP_SRLV:  begin use_reg_amt = 1'b1; sh_kind = SH_RIGHT_LOG; end
      OP_SRAV:  begin use_reg_amt = 1'b1; sh_kind = SH_RIGHT_ARI; end
      OP_ROTRV: begin use_reg_amt = 1'b1; sh_kind = SH_ROT_RIGHT; end
      default:  ;
    endcase
  end

  assign sh_amt = use_reg_amt ? opnd_s[SH_W-1:0] : shamt;

  int_alu_shifter #(.DATA_W(DATA_W), .SH_W(SH_W)) u_shift (
    .din(opnd_t), .amt(sh_amt), .kind(sh_kind), .dout(sh_v)
  );

  // Result and flag selection.
  always_comb begin
    res_c = '0;
    flg_c = '0;
    case (op)
      OP_ADD:   begin res_c = sum;  flg_c.ovf = add_ovf; end
      OP_ADDU:  res_c = sum;
      OP_SUB:   begin res_c = diff; flg_c.ovf = sub_ovf; end
      OP_SUBU:  res_c = diff;
      OP_AND:   res_c = and_v;
      OP_OR:    res_c = or_v;
      OP_XOR:   res_c = xor_v;
      OP_NOR:   res_c = nor_v;
      OP_SLT:   res_c = {{(DATA_W-1){1'b0}}, lt_s};
      OP_SLTU:  res_c = {{(DATA_W-1){1'b0}}, lt_u};
      OP_SLL, OP_SRL, OP_SRA, OP_ROTR,
      OP_SLLV, OP_SRLV, OP_SRAV, OP_ROTRV:
                res_c = sh_v;
      OP_MOVZ:  if (opnd_t == '0) res_c = opnd_s; else flg_c.discard = 1'b1;
      OP_MOVN:  if (opnd_t != '0) res_c = opnd_s; else flg_c.discard = 1'b1;
      OP_LUI:   res_c = opnd_t << HALF_W;
      OP_TGE:   flg_c.trap = ~lt_s;
      OP_TGEU:  flg_c.trap = ~lt_u;
      OP_TLT:   flg_c.trap = lt_s;
      OP_TLTU:  flg_c.trap = lt_u;
      OP_TEQ:   flg_c.trap = eq;
      OP_TNE:   flg_c.trap = ~eq;
      default:  ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result       <= '0;
      ovf_flag     <= 1'b0;
      trap_flag    <= 1'b0;
      discard_flag <= 1'b0;
    end else begin
      result       <= res_c;
      ovf_flag     <= flg_c.ovf;
      trap_flag    <= flg_c.trap;
      discard_flag <= flg_c.discard;
    end
  end
endmodule

// File: rtl/int_alu_checker.sv
module int_alu_checker #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic [4:0]        op_sel,
  input logic [DATA_W-1:0] opnd_t,
  input logic [DATA_W-1:0] result,
  input logic              ovf_flag,
  input logic              trap_flag,
  input logic              discard_flag
);
  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 5'd2 || op_sel == 5'd4) |=> !ovf_flag);

  a_r5_bool_result: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 5'd9 || op_sel == 5'd10) |=> (result[DATA_W-1:1] == '0));

  a_r9_discard_zero: assert property (@(posedge clk) disable iff (rst)
    discard_flag |-> (result == '0));

  a_r9_movz_squash: assert property (@(posedge clk) disable iff (rst)
    (op_sel == 5'd19 && opnd_t != '0) |=> discard_flag);

  a_r11_trap_zero: assert property (@(posedge clk) disable iff (rst)
    trap_flag |-> (result == '0));

  a_r12_one_flag: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ovf_flag, trap_flag, discard_flag}));

  a_r12_unknown_quiet: assert property (@(posedge clk) disable iff (rst)
    (op_sel >= 5'd28) |=> (result == '0 && !ovf_flag && !trap_flag && !discard_flag));
endmodule

bind int_alu int_alu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_t(opnd_t), .result(result),
  .ovf_flag(ovf_flag), .trap_flag(trap_flag), .discard_flag(discard_flag)
);

// File: tb/int_alu_test.sv
`timescale 1ns/1ps
module int_alu_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  op_sel = '0;
  logic [31:0] opnd_s = '0, opnd_t = '0;
  logic [4:0]  shamt = '0;
  logic [31:0] result;
  logic        ovf_flag, trap_flag, discard_flag;
  int          n_vec = 0, n_bad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  int_alu uut (
    .clk(clk), .rst(rst), .op_sel(op_sel), .opnd_s(opnd_s), .opnd_t(opnd_t),
    .shamt(shamt), .result(result), .ovf_flag(ovf_flag),
    .trap_flag(trap_flag), .discard_flag(discard_flag)
  );

  function automatic string req_of(int opc);
    case (opc)
      1, 2, 3, 4:          return "R3";
      5, 6, 7, 8:          return "R4";
      9, 10:               return "R5";
      11, 12, 13:          return "R6";
      14:                  return "R7";
      15, 16, 17, 18:      return "R8";
      19, 20:              return "R9";
      21:                  return "R10";
      22, 23, 24, 25, 26, 27: return "R11";
      default:             return "R12";
    endcase
  endfunction

  // Expected {ovf, trap, discard, result} from the requirements.
  function automatic logic [34:0] model(int opc, logic [31:0] s, logic [31:0] t, logic [4:0] sa);
    logic [31:0] r = '0;
    logic ov = 0, tr = 0, ds = 0;
    longint ws = longint'($signed(s));
    longint wt = longint'($signed(t));
    longint w;
    logic [4:0] vn = s[4:0];
    logic [63:0] tt = {t, t};
    case (opc)
      1:  begin r = s + t; w = ws + wt; ov = (w > 64'sd2147483647) || (w < -64'sd2147483648); end
      2:  r = s + t;
      3:  begin r = s - t; w = ws - wt; ov = (w > 64'sd2147483647) || (w < -64'sd2147483648); end
      4:  r = s - t;
      5:  r = s & t;
      6:  r = s | t;
      7:  r = s ^ t;
      8:  r = ~(s | t);
      9:  r = {31'd0, ws < wt};
      10: r = {31'd0, s < t};
      11: r = t << sa;
      12: r = t >> sa;
      13: r = 32'($signed(t) >>> sa);
      14: r = 32'(tt >> sa);
      15: r = t << vn;
      16: r = t >> vn;
      17: r = 32'($signed(t) >>> vn);
      18: r = 32'(tt >> vn);
      19: if (t == 0) r = s; else ds = 1;
      20: if (t != 0) r = s; else ds = 1;
      21: r = {t[15:0], 16'd0};
      22: tr = ws >= wt;
      23: tr = s >= t;
      24: tr = ws < wt;
      25: tr = s < t;
      26: tr = s == t;
      27: tr = s != t;
      default: ;
    endcase
    return {ov, tr, ds, r};
  endfunction

  task automatic compare(string req, logic [34:0] exp_v);
    logic [34:0] act = {ovf_flag, trap_flag, discard_flag, result};
    n_vec++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s op=%0d s=%h t=%h sa=%0d: got ovf/trap/disc/res=%b%b%b/%h expected %b%b%b/%h",
               req, op_sel, opnd_s, opnd_t, shamt, act[34], act[33], act[32], act[31:0],
               exp_v[34], exp_v[33], exp_v[32], exp_v[31:0]);
    end
  endtask

  task automatic drive(int opc, logic [31:0] s, logic [31:0] t, logic [4:0] sa);
    op_sel = 5'(opc); opnd_s = s; opnd_t = t; shamt = sa;
  endtask

  // Drive at a falling edge, the register captures at the next rising edge,
  // and the output is judged at the falling edge after that.
  task automatic apply(int opc, logic [31:0] s, logic [31:0] t, logic [4:0] sa);
    drive(opc, s, t, sa);
    @(negedge clk);
    compare(req_of(opc), model(opc, s, t, sa));
  endtask

  logic [31:0] corner [12] = '{32'h0, 32'h1, 32'h2, 32'h7FFFFFFF, 32'h80000000,
                               32'h80000001, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h12345678,
                               32'hDEADBEEF, 32'h0000001F, 32'h00010020};

  initial begin
    // R1: reset clears outputs while a flag-raising op is presented.
    drive(1, 32'h7FFFFFFF, 32'h1, 5'd3);
    @(negedge clk); @(negedge clk);
    compare("R1", 35'd0);
    rst = 1'b0;

    // R2: one-cycle latency, outputs hold between edges.
    apply(2, 32'd5, 32'd7, 5'd0);
    drive(2, 32'd100, 32'd1, 5'd0);
    #1 compare("R2", {3'b000, 32'd12});
    @(negedge clk);
    compare("R2", {3'b000, 32'd101});

    // Sweep every code over corner operands and varied amounts (R3..R12).
    for (int opc = 0; opc < 32; opc++)
      for (int i = 0; i < 12; i++)
        for (int j = 0; j < 12; j++)
          for (int k = 0; k < 8; k++)
            apply(opc, corner[i], corner[j], 5'(k * 4 + (i + j) % 4));

    // R7: rotate by zero returns t; R8: register amount ignores shamt and s[31:5].
    apply(14, 32'hFFFFFFFF, 32'hA5A5_0F0F, 5'd0);
    apply(18, 32'hFFFF_FFE0, 32'hA5A5_0F0F, 5'd17);
    for (int n = 0; n < 32; n++) apply(17, {27'h5A5A5A5, 5'(n)}, 32'h8000_1234, 5'(31 - n));

    // R1 again mid-run.
    rst = 1'b1;
    drive(20, 32'hCAFE, 32'd0, 5'd0);
    @(negedge clk);
    compare("R1", 35'd0);
    rst = 1'b0;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule